// File: doc/BRIEF.md
# Configurable Sum-of-Products Logic Cell

One cell of a sum-of-products programmable fabric, built for a synchronous design. Five AND terms take true or inverted literals from a shared input bus. That bus carries both the global signals and the regional signals. A per-term role code decides where each term goes. A term either feeds the OR sum or drives a control function of the cell: the cell clock, the cell reset, the output enable or the XOR input. The OR sum can take in a cascade bit from a neighbouring cell. The cell passes its sum on through a cascade output, so a chain of cells can build one wide sum.

The sum passes through an XOR stage, where a polarity bit and an optional product term can invert it. The result goes to a storage element that runs as a D flip-flop, a T flip-flop or a transparent latch. The storage element works inside one fast system clock domain. The cell clock it uses comes either from one of the global clock inputs or from a product term. The storage element sees a rising edge of that cell clock when it samples the clock high after having seen it low at the previous system edge. The pin value and the feedback value each choose on their own between the combinational result and the stored bit. This lets the cell drive its pin combinationally while it feeds back a buried registered bit. A foldback output returns the complement of one selected term to the regional bus.

All programming is held on static configuration inputs. Change them only while the system reset is high.

Top module: `plm_cell`

## Requirements
- R1: Term k is the AND of its literals. Bit k*NIN+b of `cfg_true` needs `bus_in[b]`=1, and the same bit of `cfg_comp` needs `bus_in[b]`=0. A term with no literal selected evaluates to 0.
- R2: `casc_out` is the OR of every term whose role is sum (code 0). It also includes `casc_in` when `cfg_casc_en` is 1.
- R3: The logic result equals `casc_out` XOR `cfg_pol` XOR the OR of the terms with role XOR (code 4).
- R4: The role codes are 3 bits per term, at bits [3k+2:3k]: 0 sum, 1 clock, 2 reset, 3 output enable, 4 XOR, and 5 to 7 parked. A term with a role other than sum never enters the sum. All terms that share a control role are ORed together.
- R5: `cfg_clk_src` values 0 to NGCLK-1 pick `gclk[i]` as the cell clock, and the value NGCLK picks the clock terms. With `cfg_mode`=0 (or 3), a system edge that sees the cell clock at 1 loads the logic result, provided the previous system edge saw it at 0. Without such an edge the stored bit holds.
- R6: With `cfg_mode`=1, the same cell-clock edge inverts the stored bit when the logic result is 1 and keeps it when the result is 0.
- R7: With `cfg_mode`=2, the stored bit takes the logic result at every system edge while the cell clock is 1, and holds while the cell clock is 0.
- R8: `cfg_rst_src` 1 picks `gclr` and 2 picks the reset terms, while 0 disables the cell reset. An active cell reset clears the stored bit at the next system edge in every mode, and it takes priority over a coinciding clock edge or latch enable. `rst` also clears the bit.
- R9: `pin_oe` is 1 for `cfg_oe_src`=0, `goe[i-1]` for values 1 to NGOE, and the output-enable terms for NGOE+1. `pin_oe` has no effect on `pin_out`, `fb_out` or the stored bit.
- R10: `pin_out` carries the stored bit when `cfg_out_reg`=1 and the logic result otherwise. `fb_out` chooses the same way through `cfg_fb_reg`, on its own, so a combinational pin can sit beside a buried registered feedback.
- R11: `fold_out` is the complement of term `cfg_fold_sel`, whatever that term's role is. It is 1 when the index is NPT or more.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high system reset |
| bus_in | input | NIN | Global and regional literal bus |
| gclk | input | NGCLK | Global clock inputs |
| gclr | input | 1 | Global clear input |
| goe | input | NGOE | Global output-enable inputs |
| casc_in | input | 1 | Sum from the neighbouring cell |
| cfg_true | input | NPT*NIN | True-literal select per term |
| cfg_comp | input | NPT*NIN | Inverted-literal select per term |
| cfg_role | input | NPT*3 | Role code per term |
| cfg_casc_en | input | 1 | Add casc_in to the sum |
| cfg_pol | input | 1 | Fixed inversion of the sum |
| cfg_mode | input | 2 | 0 D, 1 T, 2 latch, 3 D |
| cfg_clk_src | input | CSW | Cell clock source |
| cfg_rst_src | input | 2 | Cell reset source |
| cfg_oe_src | input | OSW | Output-enable source |
| cfg_out_reg | input | 1 | Pin driven by the stored bit |
| cfg_fb_reg | input | 1 | Feedback driven by the stored bit |
| cfg_fold_sel | input | FSW | Term index for the foldback |
| pin_out | output | 1 | Pin data |
| pin_oe | output | 1 | Pin drive enable (0 means high impedance) |
| fb_out | output | 1 | Feedback to the global bus |
| fold_out | output | 1 | Foldback to the regional bus |
| casc_out | output | 1 | Sum passed to the next cell |

## Verification
A cell reset and a cell-clock edge (or an open latch) can land on the same system edge. The bench provokes this in two ways. It gives the clock role and the reset role to terms built from the same literal, and it toggles `gclr` at random against the global clocks. The cycle-level reference model then judges the result. It clears the stored bit whenever a reset coincides with a capture, and it compares the registered feedback on the next sample. A T-mode toggle that lands on the same edge as a reset is checked the same way.

// File: rtl/plm_pkg.sv
`timescale 1ns/1ps
package plm_pkg;
    localparam int ROLE_W = 3;

    typedef enum logic [ROLE_W-1:0] {
        ROLE_SUM = 3'd0,
        ROLE_CLK = 3'd1,
        ROLE_RST = 3'd2,
        ROLE_OE  = 3'd3,
        ROLE_XOR = 3'd4
    } pt_role_e;

    localparam logic [1:0] ST_D     = 2'd0;
    localparam logic [1:0] ST_T     = 2'd1;
    localparam logic [1:0] ST_LATCH = 2'd2;

    localparam logic [1:0] RS_NONE = 2'd0;
    localparam logic [1:0] RS_GCLR = 2'd1;
    localparam logic [1:0] RS_PT   = 2'd2;

    typedef struct packed {
        logic clk;
        logic rst;
        logic oe;
        logic xr;
    } pt_ctrl_t;

    function automatic logic is_toggle(input logic [1:0] mode);
        return mode == ST_T;
    endfunction

    function automatic logic is_latch(input logic [1:0] mode);
        return mode == ST_LATCH;
    endfunction
endpackage

// File: rtl/plm_pterm_array.sv
`timescale 1ns/1ps
module plm_pterm_array #(
    parameter int NIN = 12,
    parameter int NPT = 5
) (
    input  logic [NIN-1:0]     bus_in,
    input  logic [NPT*NIN-1:0] cfg_true,
    input  logic [NPT*NIN-1:0] cfg_comp,
    output logic [NPT-1:0]     pt
);
    for (genvar k = 0; k < NPT; k++) begin : g_term
        logic [NIN-1:0] tm;
        logic [NIN-1:0] cm;
        logic [NIN-1:0] lit_ok;
        assign tm     = cfg_true[k*NIN +: NIN];
        assign cm     = cfg_comp[k*NIN +: NIN];
        assign lit_ok = (~tm | bus_in) & (~cm | ~bus_in);
        // an unprogrammed term is disabled rather than constant true
        assign pt[k]  = (|(tm | cm)) & (&lit_ok);
    end
endmodule

// File: rtl/plm_steer.sv
`timescale 1ns/1ps
module plm_steer
    import plm_pkg::*;
#(
    parameter int NPT = 5
) (
    input  logic [NPT-1:0]        pt,
    input  logic [NPT*ROLE_W-1:0] cfg_role,
    input  logic                  casc_in,
    input  logic                  cfg_casc_en,
    input  logic                  cfg_pol,
    output logic                  sum_out,
    output logic                  logic_d,
    output pt_ctrl_t              ctrl
);
    logic sum_or;

    always_comb begin
        sum_or = 1'b0;
        ctrl   = '0;
        for (int k = 0; k < NPT; k++) begin
            case (cfg_role[k*ROLE_W +: ROLE_W])
                ROLE_SUM: sum_or   = sum_or   | pt[k];
                ROLE_CLK: ctrl.clk = ctrl.clk | pt[k];
                ROLE_RST: ctrl.rst = ctrl.rst | pt[k];
                ROLE_OE:  ctrl.oe  = ctrl.oe  | pt[k];
                ROLE_XOR: ctrl.xr  = ctrl.xr  | pt[k];
                default:  ;
            endcase
        end
    end

    assign sum_out = sum_or | (cfg_casc_en & casc_in);
    assign logic_d = sum_out ^ cfg_pol ^ ctrl.xr;

    always_comb begin
        // R2
        if (cfg_casc_en && casc_in)
            casc_chain_chk: assert (sum_out == 1'b1);
    end
endmodule

// File: rtl/plm_store.sv
`timescale 1ns/1ps
module plm_store
    import plm_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] cfg_mode,
    input  logic       d,
    input  logic       cell_clk,
    input  logic       cell_rst,
    output logic       q
);
    logic clk_q;
    logic edge_seen;
    logic mode_t;
    logic mode_l;

    assign mode_t    = is_toggle(cfg_mode);
    assign mode_l    = is_latch(cfg_mode);
    assign edge_seen = cell_clk & ~clk_q;

    always_ff @(posedge clk) begin
        clk_q <= cell_clk;
        if (rst || cell_rst) begin
            q <= 1'b0;
        end else if (mode_l) begin
            if (cell_clk) q <= d;
        end else if (edge_seen) begin
            q <= mode_t ? (q ^ d) : d;
        end
    end

    // R8
    sys_rst_chk: assert property (@(posedge clk) rst |=> q == 1'b0);
    // R8
    cell_rst_chk: assert property (@(posedge clk) disable iff (rst)
        cell_rst |=> q == 1'b0);
    // R5
    d_load_chk: assert property (@(posedge clk) disable iff (rst)
        (!mode_t && !mode_l && edge_seen && !cell_rst) |=> q == $past(d));
    // R6
    t_flip_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_t && edge_seen && d && !cell_rst) |=> q != $past(q));
    // R7
    latch_open_chk: assert property (@(posedge clk) disable iff (rst)
        (mode_l && cell_clk && !cell_rst) |=> q == $past(d));
    // R5
    edge_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!mode_l && !edge_seen && !cell_rst) |=> $stable(q));
endmodule

// File: rtl/plm_cell.sv
`timescale 1ns/1ps
module plm_cell
    import plm_pkg::*;
#(
    parameter int NIN   = 12,
    parameter int NPT   = 5,
    parameter int NGCLK = 3,
    parameter int NGOE  = 2,
    localparam int CSW  = $clog2(NGCLK + 1),
    localparam int OSW  = $clog2(NGOE + 2),
    localparam int FSW  = $clog2(NPT + 1)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NIN-1:0]        bus_in,
    input  logic [NGCLK-1:0]      gclk,
    input  logic                  gclr,
    input  logic [NGOE-1:0]       goe,
    input  logic                  casc_in,
    input  logic [NPT*NIN-1:0]    cfg_true,
    input  logic [NPT*NIN-1:0]    cfg_comp,
    input  logic [NPT*ROLE_W-1:0] cfg_role,
    input  logic                  cfg_casc_en,
    input  logic                  cfg_pol,
    input  logic [1:0]            cfg_mode,
    input  logic [CSW-1:0]        cfg_clk_src,
    input  logic [1:0]            cfg_rst_src,
    input  logic [OSW-1:0]        cfg_oe_src,
    input  logic                  cfg_out_reg,
    input  logic                  cfg_fb_reg,
    input  logic [FSW-1:0]        cfg_fold_sel,
    output logic                  pin_out,
    output logic                  pin_oe,
    output logic                  fb_out,
    output logic                  fold_out,
    output logic                  casc_out
);
    logic [NPT-1:0] pt;
    logic           logic_d;
    pt_ctrl_t       ctrl;
    logic           cell_clk;
    logic           cell_rst;
    logic           q;

    plm_pterm_array #(.NIN(NIN), .NPT(NPT)) u_terms (
        .bus_in  (bus_in),
        .cfg_true(cfg_true),
        .cfg_comp(cfg_comp),
        .pt      (pt)
    );

    plm_steer #(.NPT(NPT)) u_steer (
        .pt         (pt),
        .cfg_role   (cfg_role),
        .casc_in    (casc_in),
        .cfg_casc_en(cfg_casc_en),
        .cfg_pol    (cfg_pol),
        .sum_out    (casc_out),
        .logic_d    (logic_d),
        .ctrl       (ctrl)
    );

    always_comb begin
        cell_clk = ctrl.clk;
        for (int i = 0; i < NGCLK; i++)
            if (cfg_clk_src == CSW'(i)) cell_clk = gclk[i];
    end

    always_comb begin
        case (cfg_rst_src)
            RS_GCLR: cell_rst = gclr;
            RS_PT:   cell_rst = ctrl.rst;
            default: cell_rst = 1'b0;
        endcase
    end

    always_comb begin
        pin_oe = (cfg_oe_src == '0);
        for (int i = 0; i < NGOE; i++)
            if (cfg_oe_src == OSW'(i + 1)) pin_oe = goe[i];
        if (cfg_oe_src == OSW'(NGOE + 1)) pin_oe = ctrl.oe;
    end

    always_comb begin
        fold_out = 1'b1;
        for (int k = 0; k < NPT; k++)
            if (cfg_fold_sel == FSW'(k)) fold_out = ~pt[k];
    end

    plm_store u_store (
        .clk     (clk),
        .rst     (rst),
        .cfg_mode(cfg_mode),
        .d       (logic_d),
        .cell_clk(cell_clk),
        .cell_rst(cell_rst),
        .q       (q)
    );

    assign pin_out = cfg_out_reg ? q : logic_d;
    assign fb_out  = cfg_fb_reg  ? q : logic_d;
endmodule

// File: tb/test_plm_cell.sv
`timescale 1ns/1ps
module test_plm_cell;
    localparam int NIN = 8;
    localparam int NPT = 5;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [NIN-1:0]     bus_in = '0;
    logic [2:0]         gclk = '0;
    logic               gclr = 1'b0;
    logic [1:0]         goe = '0;
    logic               casc_in = 1'b0;
    logic [NPT*NIN-1:0] cfg_true = '0;
    logic [NPT*NIN-1:0] cfg_comp = '0;
    logic [NPT*3-1:0]   cfg_role = '0;
    logic               cfg_casc_en = 1'b0;
    logic               cfg_pol = 1'b0;
    logic [1:0]         cfg_mode = '0;
    logic [1:0]         cfg_clk_src = '0;
    logic [1:0]         cfg_rst_src = '0;
    logic [1:0]         cfg_oe_src = '0;
    logic               cfg_out_reg = 1'b0;
    logic               cfg_fb_reg = 1'b1;
    logic [2:0]         cfg_fold_sel = '0;
    logic pin_out, pin_oe, fb_out, fold_out, casc_out;

    int    nchk = 0;
    int    nerr = 0;
    bit    done = 1'b0;
    string cur_req = "R8";
    bit    mq = 1'b0;
    bit    mclk_prev = 1'b0;

    always #5 clk = ~clk;

    plm_cell #(.NIN(NIN), .NPT(NPT), .NGCLK(3), .NGOE(2)) i_plm_cell (
        .clk(clk), .rst(rst), .bus_in(bus_in), .gclk(gclk), .gclr(gclr),
        .goe(goe), .casc_in(casc_in), .cfg_true(cfg_true), .cfg_comp(cfg_comp),
        .cfg_role(cfg_role), .cfg_casc_en(cfg_casc_en), .cfg_pol(cfg_pol),
        .cfg_mode(cfg_mode), .cfg_clk_src(cfg_clk_src), .cfg_rst_src(cfg_rst_src),
        .cfg_oe_src(cfg_oe_src), .cfg_out_reg(cfg_out_reg), .cfg_fb_reg(cfg_fb_reg),
        .cfg_fold_sel(cfg_fold_sel), .pin_out(pin_out), .pin_oe(pin_oe),
        .fb_out(fb_out), .fold_out(fold_out), .casc_out(casc_out)
    );

    // behavioural reference
    function automatic bit m_term(int k);
        bit any = 0;
        bit ok = 1;
        for (int b = 0; b < NIN; b++) begin
            if (cfg_true[k*NIN+b]) begin any = 1; if (!bus_in[b]) ok = 0; end
            if (cfg_comp[k*NIN+b]) begin any = 1; if (bus_in[b]) ok = 0; end
        end
        return any && ok;
    endfunction

    function automatic bit m_role(int r);
        bit v = 0;
        for (int k = 0; k < NPT; k++)
            if (int'(cfg_role[k*3 +: 3]) == r && m_term(k)) v = 1;
        return v;
    endfunction

    function automatic bit m_sum();
        return m_role(0) || (cfg_casc_en && casc_in);
    endfunction

    function automatic bit m_d();
        return m_sum() ^ cfg_pol ^ m_role(4);
    endfunction

    function automatic bit m_cclk();
        if (int'(cfg_clk_src) < 3) return gclk[cfg_clk_src];
        return m_role(1);
    endfunction

    function automatic bit m_crst();
        if (cfg_rst_src == 2'd1) return gclr;
        if (cfg_rst_src == 2'd2) return m_role(2);
        return 0;
    endfunction

    function automatic bit m_oe();
        case (cfg_oe_src)
            2'd0: return 1;
            2'd1: return goe[0];
            2'd2: return goe[1];
            default: return m_role(3);
        endcase
    endfunction

    function automatic bit m_fold();
        if (int'(cfg_fold_sel) < NPT) return !m_term(int'(cfg_fold_sel));
        return 1;
    endfunction

    always @(posedge clk) begin
        bit c;
        bit dv;
        c  = m_cclk();
        dv = m_d();
        if (rst || m_crst()) mq = 0;
        else if (cfg_mode == 2'd2) begin
            if (c) mq = dv;
        end else if (c && !mclk_prev) begin
            if (cfg_mode == 2'd1) mq = mq ^ dv;
            else mq = dv;
        end
        mclk_prev = c;
    end

    task automatic chk(string req, string nm, logic act, logic exp);
        nchk++;
        if (act !== exp) begin
            nerr++;
            $display("FAIL %s %s actual=%b expected=%b at %0t", req, nm, act, exp, $time);
        end
    endtask

    task automatic tick();
        @(negedge clk);
        chk("R2", "casc_out", casc_out, m_sum());
        chk("R11", "fold_out", fold_out, m_fold());
        chk("R9", "pin_oe", pin_oe, m_oe());
        chk(cur_req, "pin_out", pin_out, cfg_out_reg ? mq : m_d());
        chk(cur_req, "fb_out", fb_out, cfg_fb_reg ? mq : m_d());
    endtask

    task automatic run(string tag, int n);
        cur_req = tag;
        for (int i = 0; i < n; i++) begin
            bus_in  = NIN'($urandom);
            gclk    = 3'($urandom);
            gclr    = ($urandom % 5) == 0;
            goe     = 2'($urandom);
            casc_in = 1'($urandom);
            tick();
        end
    endtask

    task automatic set_term(int k, logic [NIN-1:0] t, logic [NIN-1:0] c, logic [2:0] r);
        cfg_true[k*NIN +: NIN] = t;
        cfg_comp[k*NIN +: NIN] = c;
        cfg_role[k*3 +: 3]     = r;
    endtask

    initial begin
        for (int k = 0; k < NPT; k++) set_term(k, '0, '0, 3'd7);
        run("R8", 3);            // reset state: stored bit 0
        rst = 1'b0;
        // R1: two-literal term and an empty term, combinational view
        set_term(0, 8'h01, 8'h02, 3'd0);
        set_term(1, 8'h00, 8'h00, 3'd0);
        cfg_fb_reg = 1'b0;
        run("R1", 60);
        // R2: cascade input joins the sum
        cfg_casc_en = 1'b1;
        set_term(2, 8'h04, 8'h00, 3'd0);
        run("R2", 40);
        // R3: polarity bit and XOR term
        cfg_pol = 1'b1;
        set_term(4, 8'h10, 8'h00, 3'd4);
        run("R3", 40);
        // R4: terms stolen for clock and reset roles
        set_term(1, 8'h08, 8'h00, 3'd1);
        set_term(3, 8'h20, 8'h00, 3'd2);
        cfg_clk_src = 2'd3; cfg_rst_src = 2'd2; cfg_fb_reg = 1'b1;
        run("R4", 80);
        // R5: D mode on global clocks
        cfg_rst_src = 2'd0; cfg_clk_src = 2'd0; cfg_mode = 2'd0;
        run("R5", 80);
        cfg_clk_src = 2'd2;
        run("R5", 40);
        cfg_mode = 2'd3;
        run("R5", 40);
        // R6: toggle mode
        cfg_mode = 2'd1; cfg_clk_src = 2'd1;
        run("R6", 100);
        // R7: transparent latch
        cfg_mode = 2'd2;
        run("R7", 80);
        // R8: global clear, then reset term built on the clock literal
        cfg_mode = 2'd0; cfg_rst_src = 2'd1;
        run("R8", 60);
        cfg_clk_src = 2'd3; cfg_rst_src = 2'd2;
        set_term(3, 8'h08, 8'h00, 3'd2);
        run("R8", 40);
        set_term(3, 8'h08, 8'h40, 3'd2);
        cfg_mode = 2'd1;
        run("R8", 40);
        rst = 1'b1; run("R8", 2); rst = 1'b0;
        // R9: output-enable sources; pin data keeps following
        set_term(2, 8'h04, 8'h00, 3'd3);
        for (int s = 0; s < 4; s++) begin
            cfg_oe_src = 2'(s);
            run("R9", 30);
        end
        // R10: combinational pin with buried register, and the reverse
        cfg_mode = 2'd0; cfg_clk_src = 2'd0;
        cfg_out_reg = 1'b0; cfg_fb_reg = 1'b1;
        run("R10", 60);
        cfg_out_reg = 1'b1; cfg_fb_reg = 1'b0;
        run("R10", 60);
        // R11: every foldback index including out-of-range ones
        for (int s = 0; s < 8; s++) begin
            cfg_fold_sel = 3'(s);
            run("R11", 12);
        end
        // mixed random configurations
        for (int blk = 0; blk < 60; blk++) begin
            for (int k = 0; k < NPT; k++) begin
                logic [NIN-1:0] t;
                t = NIN'($urandom & $urandom & $urandom);
                set_term(k, t, NIN'($urandom & $urandom & $urandom) & ~t,
                         3'($urandom % 6));
            end
            cfg_casc_en  = 1'($urandom);
            cfg_pol      = 1'($urandom);
            cfg_mode     = 2'($urandom);
            cfg_clk_src  = 2'($urandom);
            cfg_rst_src  = 2'($urandom % 3);
            cfg_oe_src   = 2'($urandom);
            cfg_out_reg  = 1'($urandom);
            cfg_fb_reg   = 1'($urandom);
            cfg_fold_sel = 3'($urandom);
            run("R6", 50);
        end
        if (!done) begin
            done = 1'b1;
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            nchk++;
            nerr++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", nchk, nerr);
            $finish;
        end
    end
endmodule